// File: doc/BRIEF.md
# Command Status Ring Writer

This block sits behind a command execution engine. Each time the engine finishes a command, it hands over one completion event. The event carries the command's sequence number, a two-bit outcome and an error flag. The block turns the event into a fixed-length status record and stores that record into a circular ring in memory. It moves one 32-bit word per handshake and raises an interrupt once the whole record is in place. The block owns four pieces of state: the ring write slot, a four-bit pass counter, a microsecond timer and the interrupt.

The timer measures how long the command actually executed. It is restarted by the engine's start pulse and frozen when the completion event is accepted, so time spent waiting in the command queue never counts. The last word of every record carries the pass counter. A consumer can compare its low bit against the value it expects and so find where fresh records end, without fetching a head pointer.

Top module: `status_ring_writer`

## Requirements
- R1: Record word 0 holds the sequence number in bits [15:0], the execution time in microseconds in bits [25:16] and the outcome code in bits [27:26]. The outcome codes are 0 ok, 1 blocked queue or cache, 2 failed and 3 resource blocked. Bits [31:28] are zero.
- R2: Record word 1 equals the value on `stamp_i` in the cycle in which the completion event is accepted.
- R3: Bit 0 of record word 2 carries the error flag for outcomes 0 and 1 and is forced to zero for outcomes 2 and 3. Every other bit of word 2 is zero, every bit of words 3 through WORDS-2 is zero, and bits [27:0] of the last word are zero.
- R4: Let d be the number of rising edges from the edge that samples `exec_start_i` to the edge that accepts the completion event. The execution time is floor((d-1)/CYC_PER_US) and saturates at 1023. Cycles before the start pulse do not count.
- R5: The words of a record are issued in order 0 to WORDS-1 at address slot*WORDS+word. The n-th record after reset (counting from 0) goes to slot n mod ENTRIES.
- R6: Bits [31:28] of the last word hold the pass count. It is 0 for records written before the first wrap of the slot pointer and rises by one at each wrap, modulo 16.
- R7: `irq_o` is high for exactly one cycle, in the cycle after the last word of a record is accepted.
- R8: `done_ready_o` stays low from the acceptance of an event until the interrupt cycle. An event presented in that window is not taken and does not alter the record being written.
- R9: Once `mem_req_o` is high without `mem_ack_i`, it stays high in the next cycle with the same address and data.
- R10: After reset `done_ready_o` is 1, while `mem_req_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_start_i | input | 1 | Pulse: a command begins executing; restarts the timer |
| done_valid_i | input | 1 | Completion event present |
| done_ready_o | output | 1 | Block can take a completion event |
| done_seq_i | input | 16 | Sequence number of the completed command |
| done_outcome_i | input | 2 | Outcome code (0 ok, 1 blocked, 2 failed, 3 resource blocked) |
| done_err_i | input | 1 | Blocking resource was already in use |
| stamp_i | input | 32 | Free-running timestamp |
| mem_req_o | output | 1 | Word write request |
| mem_addr_o | output | $clog2(ENTRIES*WORDS) | Word address inside the ring |
| mem_wdata_o | output | 32 | Word write data |
| mem_ack_i | input | 1 | Memory accepts the word this cycle |
| irq_o | output | 1 | One-cycle pulse after a record is complete |

## Verification
The bench builds the block with ENTRIES = 3 and CYC_PER_US = 2. With three slots, the pass counter wraps from 15 back to 0 after 48 records, which takes only a few thousand cycles. With two cycles per microsecond, the timer reaches its 1023 ceiling after about 2050 cycles. The memory model alternates between accepting every word and stalling two cycles out of three, so that hold behaviour and the interrupt timing are exercised under both patterns.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned SEQ_W  = 16;
  localparam int unsigned TIME_W = 10;
  localparam int unsigned OUT_W  = 2;
  localparam int unsigned PASS_W = 4;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [OUT_W-1:0] {
    OUT_OK          = 2'd0,
    OUT_BLOCKED     = 2'd1,
    OUT_FAILED      = 2'd2,
    OUT_RES_BLOCKED = 2'd3
  } outcome_e;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [TIME_W-1:0] exec_us;
    outcome_e          outcome;
    logic              err;
    logic [DATA_W-1:0] stamp;
  } status_rec_t;

  // error flag is only meaningful when the command ran at all
  function automatic logic err_visible(input status_rec_t r);
    return r.err && (r.outcome == OUT_OK || r.outcome == OUT_BLOCKED);
  endfunction

  // compose one word of a record
  function automatic logic [DATA_W-1:0] pack_word(input int unsigned idx,
                                                  input int unsigned last_idx,
                                                  input status_rec_t r,
                                                  input logic [PASS_W-1:0] pass);
    logic [DATA_W-1:0] w;
    w = '0;
    if (idx == 0)
      w = {4'b0000, r.outcome, r.exec_us, r.seq};
    else if (idx == 1)
      w = r.stamp;
    else if (idx == 2)
      w = {31'b0, err_visible(r)};
    if (idx == last_idx)
      w = {pass, 28'b0};
    return w;
  endfunction

  // word address of a record word inside the ring
  function automatic int unsigned word_addr(input int unsigned slot,
                                            input int unsigned idx,
                                            input int unsigned words);
    return slot * words + idx;
  endfunction
endpackage

// File: rtl/srw_exec_timer.sv
module srw_exec_timer #(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned TIME_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [TIME_W-1:0] us_o
);
  localparam int unsigned PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(CYC_PER_US - 1);
  localparam logic [TIME_W-1:0] US_MAX   = '1;

  logic [PRE_W-1:0] pre_q;
  logic             run_q;
  logic             us_tick;

  assign us_tick = run_q && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_o  <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      pre_q <= '0;
      us_o  <= '0;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      pre_q <= us_tick ? '0 : pre_q + 1'b1;
      if (us_tick && us_o != US_MAX) us_o <= us_o + 1'b1;
    end
  end

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (us_o == US_MAX && !start_i) |=> (us_o == US_MAX));
  a_r4_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && us_o != US_MAX) |=> (us_o == $past(us_o) || us_o == $past(us_o) + 1'b1));
endmodule

// File: rtl/srw_ring_ptr.sv
module srw_ring_ptr #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned PASS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [(ENTRIES > 1 ? $clog2(ENTRIES) : 1)-1:0] slot_o,
  output logic [PASS_W-1:0] pass_o,
  output logic              wrap_o
);
  localparam int unsigned SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(ENTRIES - 1);

  assign wrap_o = adv_i && (slot_o == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_o <= '0;
      pass_o <= '0;
    end else if (adv_i) begin
      slot_o <= wrap_o ? '0 : slot_o + 1'b1;
      if (wrap_o) pass_o <= pass_o + 1'b1;
    end
  end

  a_r6_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (pass_o == $past(pass_o) + 1'b1) && (slot_o == '0));
  a_r6_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(pass_o));
  a_r5_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o <= SLOT_LAST);
endmodule

// File: rtl/srw_word_seq.sv
module srw_word_seq #(
  parameter int unsigned WORDS = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic ack_i,
  output logic req_o,
  output logic [$clog2(WORDS)-1:0] idx_o,
  output logic last_ack_o
);
  localparam int unsigned IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  logic word_ack;
  assign word_ack   = req_o && ack_i;
  assign last_ack_o = word_ack && (idx_o == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_o <= 1'b0;
      idx_o <= '0;
    end else if (!req_o) begin
      if (launch_i) begin
        req_o <= 1'b1;
        idx_o <= '0;
      end
    end else if (word_ack) begin
      if (last_ack_o) req_o <= 1'b0;
      else            idx_o <= idx_o + 1'b1;
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(idx_o)));
  a_r5_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ack && !last_ack_o) |=> (idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/status_ring_writer.sv
module status_ring_writer #(
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned WORDS      = 26,
  parameter int unsigned CYC_PER_US = 100,
  localparam int unsigned ADDR_W    = $clog2(ENTRIES * WORDS),
  localparam int unsigned SLOT_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_start_i,
  input  logic              done_valid_i,
  output logic              done_ready_o,
  input  logic [15:0]       done_seq_i,
  input  logic [1:0]        done_outcome_i,
  input  logic              done_err_i,
  input  logic [31:0]       stamp_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  output logic              irq_o
);
  import srw_pkg::*;

  logic              accept;
  logic              last_ack;
  logic [IDX_W-1:0]  word_idx;
  logic [SLOT_W-1:0] slot;
  logic [PASS_W-1:0] pass;
  logic              wrap;
  logic [TIME_W-1:0] exec_us;
  status_rec_t       rec_q;

  assign done_ready_o = !mem_req_o;
  assign accept       = done_valid_i && done_ready_o;

  srw_exec_timer #(.CYC_PER_US(CYC_PER_US), .TIME_W(TIME_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_i(exec_start_i), .stop_i(accept), .us_o(exec_us)
  );

  srw_word_seq #(.WORDS(WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .launch_i(accept), .ack_i(mem_ack_i),
    .req_o(mem_req_o), .idx_o(word_idx), .last_ack_o(last_ack)
  );

  srw_ring_ptr #(.ENTRIES(ENTRIES), .PASS_W(PASS_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .adv_i(last_ack), .slot_o(slot), .pass_o(pass), .wrap_o(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= last_ack;
      if (accept) begin
        rec_q.seq     <= done_seq_i;
        rec_q.exec_us <= exec_us;
        rec_q.outcome <= outcome_e'(done_outcome_i);
        rec_q.err     <= done_err_i;
        rec_q.stamp   <= stamp_i;
      end
    end
  end

  assign mem_wdata_o = pack_word(int'(word_idx), WORDS - 1, rec_q, pass);
  assign mem_addr_o  = ADDR_W'(word_addr(int'(slot), int'(word_idx), WORDS));

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    last_ack |=> irq_o);
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !done_ready_o);
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
  a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (int'(mem_addr_o) < ENTRIES * WORDS));
  a_r1_top_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && word_idx == '0) |-> (mem_wdata_o[31:28] == 4'b0000));
endmodule

// File: tb/status_ring_writer_tb_top.sv
module status_ring_writer_tb_top;
  localparam int unsigned ENTRIES = 3;
  localparam int unsigned WORDS   = 26;
  localparam int unsigned CPU     = 2;
  localparam int unsigned ADDR_W  = $clog2(ENTRIES * WORDS);

  typedef struct packed {
    logic [15:0] seq;
    logic [1:0]  outcome;
    logic        err;
    logic [15:0] dur;
    logic [7:0]  idle;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h1234, 2'd0, 1'b0, 16'd1,    8'd0},
    '{16'hBEEF, 2'd1, 1'b1, 16'd9,    8'd40},
    '{16'hFFFF, 2'd0, 1'b1, 16'd30,   8'd3},
    '{16'h0001, 2'd2, 1'b1, 16'd5,    8'd1},
    '{16'h8000, 2'd3, 1'b1, 16'd4,    8'd2},
    '{16'h0F0F, 2'd1, 1'b0, 16'd2,    8'd60},
    '{16'h5555, 2'd0, 1'b0, 16'd2100, 8'd0}
  };

  logic clk = 0, rst_n = 0;
  logic exec_start_i = 0, done_valid_i = 0, done_err_i = 0, mem_ack_i = 0;
  logic [15:0] done_seq_i = 0;
  logic [1:0]  done_outcome_i = 0;
  logic [31:0] stamp_i = 0;
  logic done_ready_o, mem_req_o, irq_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;

  status_ring_writer #(.ENTRIES(ENTRIES), .WORDS(WORDS), .CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .exec_start_i(exec_start_i), .done_valid_i(done_valid_i),
    .done_ready_o(done_ready_o), .done_seq_i(done_seq_i), .done_outcome_i(done_outcome_i),
    .done_err_i(done_err_i), .stamp_i(stamp_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, entry_n = 0;
  bit stall_mode = 0;
  logic [31:0] got_d [WORDS];
  int          got_a [WORDS];
  int wpos = 0, last_ack_cyc = -10, ready_viol = 0, hold_viol = 0;
  logic prev_wait = 0;
  logic [31:0] prev_d;
  logic [ADDR_W-1:0] prev_a;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 mem_ack_i = stall_mode ? ((cyc % 3) == 0) : 1'b1;
  end

  // port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait && (!mem_req_o || mem_addr_o != prev_a || mem_wdata_o != prev_d)) hold_viol++;
      prev_wait = mem_req_o && !mem_ack_i;
      prev_a = mem_addr_o; prev_d = mem_wdata_o;
      if (mem_req_o && done_ready_o) ready_viol++;
      if (mem_req_o && mem_ack_i && wpos < WORDS) begin
        got_d[wpos] = mem_wdata_o;
        got_a[wpos] = int'(mem_addr_o);
        wpos++;
        if (wpos == WORDS) last_ack_cyc = cyc;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [15:0] s, input logic [1:0] o, input logic e,
                         input int d, input int idle, input bit noise);
    logic [31:0] stamp_v, w0, exp_last;
    int slot, pass, us, irq_cyc, guard;
    bit irq_again;
    bit ok;
    while (!done_ready_o) @(negedge clk);
    repeat (idle) @(negedge clk);
    wpos = 0; ready_viol = 0; hold_viol = 0;
    exec_start_i = 1;
    @(negedge clk);
    exec_start_i = 0;
    repeat (d - 1) @(negedge clk);
    stamp_v = 32'hC0DE_0000 + entry_n * 32'h111;
    stamp_i = stamp_v;
    done_valid_i = 1; done_seq_i = s; done_outcome_i = o; done_err_i = e;
    @(negedge clk);
    stamp_i = ~stamp_v;
    if (noise) begin done_seq_i = ~s; done_outcome_i = ~o; done_err_i = ~e; end
    else done_valid_i = 0;
    guard = 0;
    while (!irq_o && guard < 3000) begin @(negedge clk); guard++; end
    done_valid_i = 0;
    irq_cyc = cyc;
    @(negedge clk);
    irq_again = irq_o;

    slot = entry_n % ENTRIES;
    pass = (entry_n / ENTRIES) % 16;
    us = (d - 1) / CPU; if (us > 1023) us = 1023;
    w0 = {4'b0, o, 10'(us), s};
    exp_last = {4'(pass), 28'b0};

    check(wpos == WORDS && got_d[0] == w0, "R1 word0", got_d[0], w0);
    check(got_d[0][25:16] == 10'(us), "R4 exec time", 32'(got_d[0][25:16]), 32'(us));
    check(got_d[1] == stamp_v, "R2 stamp", got_d[1], stamp_v);
    check(got_d[2] == {31'b0, e && o < 2}, "R3 error flag", got_d[2], {31'b0, e && o < 2});
    ok = 1;
    for (int i = 3; i < WORDS - 1; i++) if (got_d[i] != 0) ok = 0;
    check(ok && got_d[WORDS-1][27:0] == 0, "R3 zero fill", got_d[WORDS-1], exp_last);
    ok = 1;
    for (int i = 0; i < WORDS; i++) if (got_a[i] != slot * WORDS + i) ok = 0;
    check(ok, "R5 addresses", 32'(got_a[0]), 32'(slot * WORDS));
    check(got_d[WORDS-1][31:28] == 4'(pass), "R6 pass count", 32'(got_d[WORDS-1][31:28]), 32'(pass));
    check(irq_cyc == last_ack_cyc + 1 && !irq_again, "R7 irq pulse", 32'(irq_cyc), 32'(last_ack_cyc + 1));
    check(ready_viol == 0, "R8 ready low while busy", 32'(ready_viol), 0);
    check(hold_viol == 0, "R9 hold under stall", 32'(hold_viol), 0);
    entry_n++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done_ready_o == 1 && mem_req_o == 0 && irq_o == 0, "R10 reset state",
          {29'b0, done_ready_o, mem_req_o, irq_o}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    foreach (VEC[k]) begin
      stall_mode = k[0];
      run_cmd(VEC[k].seq, VEC[k].outcome, VEC[k].err, int'(VEC[k].dur), int'(VEC[k].idle), 1'b0);
    end
    // R8: event held during writing must not be taken or corrupt the record
    stall_mode = 1;
    run_cmd(16'hA0A0, 2'd1, 1'b1, 6, 2, 1'b1);
    check(done_ready_o == 1 && mem_req_o == 0, "R8 no extra record",
          {30'b0, done_ready_o, mem_req_o}, 32'h2);
    // R6: run past sixteen passes so the count wraps from 15 to 0
    stall_mode = 0;
    while (entry_n < 16 * ENTRIES + 2) begin
      stall_mode = entry_n[1];
      run_cmd(16'(entry_n), 2'(entry_n), entry_n[0], 3, 0, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule